// File: doc/BRIEF.md
# Pipeline Operand Forwarding Unit

This block sits beside the execute stage of a five-stage integer pipeline and decides, for each of the two ALU operands, where the value should come from. The operand can come from the register-file value captured when the instruction left decode, from the ALU result of the instruction one stage ahead (the execute/memory register), or from the value about to be written back (the memory/writeback register). The writeback value may be loaded data or an older ALU result. The decision compares the execute-stage source register numbers against the destination register and write-enable flag of each later stage.

Each operand has its own 2-bit select code and its own three-input mux. Both are held in one wrapper so that the chosen operand values appear at the ports next to the select codes. Only a true read-after-write dependency causes forwarding. A producer one stage ahead holds a newer value than one two stages ahead, so it takes precedence. Register 0 is hard-wired to zero, so it is never forwarded. Stall generation, branch flushing, the ALU and the register file are outside this block.

Top module: `fwd_unit_top`

## Requirements
- R1: When neither later stage matches a source register, that operand's select is 00 and the operand equals its register-file input.
- R2: A source register equal to the execute/memory destination, with that stage's write flag high and a nonzero destination, gives select 10 and the operand equals the execute/memory ALU result. This is the back-to-back dependent case.
- R3: A source register that matches only the memory/writeback destination, under the same write-flag and nonzero rules, gives select 01 and the operand equals the writeback value.
- R4: When both later stages match the same source register, select 10 is chosen and the execute/memory ALU result is passed.
- R5: A stage whose write flag is low never causes forwarding. The select falls back to the other stage if that stage matches, and otherwise to 00.
- R6: A destination register number of 0 never causes forwarding, even with the write flag high.
- R7: Operand A and operand B are selected independently. In the same cycle, one operand may forward from one stage while the other forwards from the other stage or from neither.
- R8: The select outputs are never 11. An operand mux driven with code 11 passes its register-file input.
- R9: A later stage that writes a register the execute-stage instruction does not read (write-after-write and write-after-read patterns) leaves the selects at 00. Two instructions that only read the same register (read-after-read) also leave the selects at 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_a | input | RIDX_W | Source register number for operand A, execute stage |
| ex_src_b | input | RIDX_W | Source register number for operand B, execute stage |
| ex_rf_a | input | XLEN | Register-file value for operand A captured at decode |
| ex_rf_b | input | XLEN | Register-file value for operand B captured at decode |
| xm_dst | input | RIDX_W | Destination register in the execute/memory register |
| xm_wen | input | 1 | Register-write flag in the execute/memory register |
| xm_alu | input | XLEN | ALU result in the execute/memory register |
| mw_dst | input | RIDX_W | Destination register in the memory/writeback register |
| mw_wen | input | 1 | Register-write flag in the memory/writeback register |
| mw_val | input | XLEN | Writeback value (load data or older ALU result) |
| sel_a | output | 2 | Select code for operand A: 00 register file, 10 exec/mem, 01 writeback |
| sel_b | output | 2 | Select code for operand B, same encoding |
| opnd_a | output | XLEN | Selected operand A to the ALU |
| opnd_b | output | XLEN | Selected operand B to the ALU |

## Verification
The block has no state, so any fault shows up at the select and operand ports in the same cycle as the input pattern that triggers it. A faulty comparator or priority stage shows up in one of three ways: a select that points at the wrong stage, an operand carrying a stale value, or code 11. The directed scenarios therefore include the cases where these differ: both stages matching, write flags low, destination 0, and the two operands pulled from different stages at once. Distinct data values on every source make any wrong pick visible in the operand value.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   // Operand source select codes; the encoding is part of the interface.
   typedef enum logic [1:0] {
      FWD_RF   = 2'b00,
      FWD_WB   = 2'b01,
      FWD_XM   = 2'b10,
      FWD_RSVD = 2'b11
   } fwd_sel_e;

   localparam int unsigned FWD_NUM_OPND = 2;

endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
   parameter int unsigned RIDX_W       = 5,
   parameter bit          HAS_ZERO_REG = 1'b1
) (
   input  logic [RIDX_W-1:0] src,
   input  logic [RIDX_W-1:0] dst,
   input  logic              wen,
   output logic              hit
);

   if (RIDX_W < 1) begin : g_bad_width
      $error("fwd_match: RIDX_W must be at least 1");
   end

   logic same_reg;
   assign same_reg = (src == dst);

   if (HAS_ZERO_REG) begin : g_zero_guard
      logic dst_live;
      assign dst_live = (dst != '0);
      assign hit = wen && dst_live && same_reg;

      always_comb begin
         if (!$isunknown({dst, wen, hit})) begin
            // R6: register 0 never produces a hit
            a_r6_zero_no_hit: assert (!(hit && dst == '0))
               else $error("a_r6_zero_no_hit");
         end
      end
   end else begin : g_no_zero_guard
      assign hit = wen && same_reg;
   end

   always_comb begin
      if (!$isunknown({wen, hit})) begin
         // R5: a stage with write flag low never hits
         a_r5_wen_low_no_hit: assert (!(hit && !wen))
            else $error("a_r5_wen_low_no_hit");
      end
   end

endmodule

// File: rtl/fwd_prio.sv
module fwd_prio
   import fwd_pkg::*;
(
   input  logic     xm_hit,
   input  logic     mw_hit,
   output fwd_sel_e sel
);

   always_comb begin
      if (xm_hit)      sel = FWD_XM;
      else if (mw_hit) sel = FWD_WB;
      else             sel = FWD_RF;
   end

   always_comb begin
      if (!$isunknown({xm_hit, mw_hit, sel})) begin
         // R4: the newer stage wins whenever it matches
         a_r4_xm_priority: assert (!xm_hit || sel == FWD_XM)
            else $error("a_r4_xm_priority");
         // R8: reserved code never leaves the selector
         a_r8_no_code11: assert (sel != FWD_RSVD)
            else $error("a_r8_no_code11");
         // R1: no match keeps the register-file source
         a_r1_idle_rf: assert (xm_hit || mw_hit || sel == FWD_RF)
            else $error("a_r1_idle_rf");
      end
   end

endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
   import fwd_pkg::*;
#(
   parameter int unsigned XLEN = 32
) (
   input  logic [1:0]      sel,
   input  logic [XLEN-1:0] rf_val,
   input  logic [XLEN-1:0] xm_val,
   input  logic [XLEN-1:0] mw_val,
   output logic [XLEN-1:0] y
);

   if (XLEN < 1) begin : g_bad_xlen
      $error("fwd_opmux: XLEN must be at least 1");
   end

   always_comb begin
      unique case (sel)
         FWD_XM:  y = xm_val;
         FWD_WB:  y = mw_val;
         default: y = rf_val;
      endcase
   end

   always_comb begin
      if (!$isunknown({sel, y, rf_val})) begin
         // R8: code 11 falls back to the register-file value
         a_r8_code11_rf: assert (sel != FWD_RSVD || y == rf_val)
            else $error("a_r8_code11_rf");
      end
   end

endmodule

// File: rtl/fwd_unit_top.sv
module fwd_unit_top
   import fwd_pkg::*;
#(
   parameter int unsigned XLEN         = 32,
   parameter int unsigned RIDX_W       = 5,
   parameter bit          HAS_ZERO_REG = 1'b1
) (
   input  logic [RIDX_W-1:0] ex_src_a,
   input  logic [RIDX_W-1:0] ex_src_b,
   input  logic [XLEN-1:0]   ex_rf_a,
   input  logic [XLEN-1:0]   ex_rf_b,
   input  logic [RIDX_W-1:0] xm_dst,
   input  logic              xm_wen,
   input  logic [XLEN-1:0]   xm_alu,
   input  logic [RIDX_W-1:0] mw_dst,
   input  logic              mw_wen,
   input  logic [XLEN-1:0]   mw_val,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b,
   output logic [XLEN-1:0]   opnd_a,
   output logic [XLEN-1:0]   opnd_b
);

   localparam int unsigned NOPND = FWD_NUM_OPND;

   if (XLEN < 1 || RIDX_W < 1) begin : g_bad_params
      $error("fwd_unit_top: XLEN and RIDX_W must be positive");
   end

   logic [NOPND-1:0][RIDX_W-1:0] src_v;
   logic [NOPND-1:0][XLEN-1:0]   rf_v;
   logic [NOPND-1:0][XLEN-1:0]   opnd_v;
   logic [NOPND-1:0][1:0]        sel_v;
   logic [NOPND-1:0]             xm_hit_v;
   logic [NOPND-1:0]             mw_hit_v;

   assign src_v = {ex_src_b, ex_src_a};
   assign rf_v  = {ex_rf_b, ex_rf_a};

   for (genvar i = 0; i < NOPND; i++) begin : g_opnd
      fwd_sel_e sel_e;

      fwd_match #(.RIDX_W(RIDX_W), .HAS_ZERO_REG(HAS_ZERO_REG)) u_xm_match (
         .src (src_v[i]),
         .dst (xm_dst),
         .wen (xm_wen),
         .hit (xm_hit_v[i])
      );

      fwd_match #(.RIDX_W(RIDX_W), .HAS_ZERO_REG(HAS_ZERO_REG)) u_mw_match (
         .src (src_v[i]),
         .dst (mw_dst),
         .wen (mw_wen),
         .hit (mw_hit_v[i])
      );

      fwd_prio u_prio (
         .xm_hit (xm_hit_v[i]),
         .mw_hit (mw_hit_v[i]),
         .sel    (sel_e)
      );

      assign sel_v[i] = sel_e;

      fwd_opmux #(.XLEN(XLEN)) u_mux (
         .sel    (sel_v[i]),
         .rf_val (rf_v[i]),
         .xm_val (xm_alu),
         .mw_val (mw_val),
         .y      (opnd_v[i])
      );

      always_comb begin
         if (!$isunknown({sel_v[i], opnd_v[i], xm_alu, mw_val})) begin
            // R2: select 10 delivers the exec/mem ALU result
            a_r2_xm_data: assert (sel_v[i] != FWD_XM || opnd_v[i] == xm_alu)
               else $error("a_r2_xm_data");
            // R3: select 01 delivers the writeback value
            a_r3_wb_data: assert (sel_v[i] != FWD_WB || opnd_v[i] == mw_val)
               else $error("a_r3_wb_data");
         end
      end
   end

   assign sel_a  = sel_v[0];
   assign sel_b  = sel_v[1];
   assign opnd_a = opnd_v[0];
   assign opnd_b = opnd_v[1];

endmodule

// File: tb/fwd_unit_top_bench.sv
module fwd_unit_top_bench;

   localparam int XLEN   = 32;
   localparam int RIDX_W = 5;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;   // 200 MHz

   logic [RIDX_W-1:0] ex_src_a, ex_src_b, xm_dst, mw_dst;
   logic [XLEN-1:0]   ex_rf_a, ex_rf_b, xm_alu, mw_val;
   logic              xm_wen, mw_wen;
   logic [1:0]        sel_a, sel_b;
   logic [XLEN-1:0]   opnd_a, opnd_b;

   logic [1:0]        m_sel;
   logic [XLEN-1:0]   m_y;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   fwd_unit_top #(.XLEN(XLEN), .RIDX_W(RIDX_W)) u_fwd_unit_top (
      .ex_src_a (ex_src_a), .ex_src_b (ex_src_b),
      .ex_rf_a  (ex_rf_a),  .ex_rf_b  (ex_rf_b),
      .xm_dst   (xm_dst),   .xm_wen   (xm_wen),   .xm_alu (xm_alu),
      .mw_dst   (mw_dst),   .mw_wen   (mw_wen),   .mw_val (mw_val),
      .sel_a    (sel_a),    .sel_b    (sel_b),
      .opnd_a   (opnd_a),   .opnd_b   (opnd_b)
   );

   // Stand-alone operand mux to reach the reserved code
   fwd_opmux #(.XLEN(XLEN)) u_mux_chk (
      .sel (m_sel), .rf_val (32'hAAAA_0001), .xm_val (32'hBBBB_0002),
      .mw_val (32'hCCCC_0003), .y (m_y)
   );

   task automatic chk(input string req, input string what,
                      input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Drive a full input set away from the clock edge, then let it settle
   task automatic apply(input int sa, input int sb, input int xd, input bit xw,
                        input int md, input bit mwn);
      @(negedge clk);
      ex_src_a = RIDX_W'(sa);
      ex_src_b = RIDX_W'(sb);
      xm_dst   = RIDX_W'(xd);
      xm_wen   = xw;
      mw_dst   = RIDX_W'(md);
      mw_wen   = mwn;
      #1;
   endtask

   task automatic expect_pair(input string req, input logic [1:0] ea, input logic [1:0] eb);
      logic [XLEN-1:0] va, vb;
      va = (ea == 2'b10) ? xm_alu : (ea == 2'b01) ? mw_val : ex_rf_a;
      vb = (eb == 2'b10) ? xm_alu : (eb == 2'b01) ? mw_val : ex_rf_b;
      chk(req, "sel_a", XLEN'(sel_a), XLEN'(ea));
      chk(req, "sel_b", XLEN'(sel_b), XLEN'(eb));
      chk(req, "opnd_a", opnd_a, va);
      chk(req, "opnd_b", opnd_b, vb);
   endtask

   task automatic t_r1_idle();
      apply(3, 4, 0, 1'b0, 0, 1'b0);
      expect_pair("R1", 2'b00, 2'b00);
      apply(3, 4, 7, 1'b1, 9, 1'b1);
      expect_pair("R1", 2'b00, 2'b00);
   endtask

   task automatic t_r2_back_to_back();
      apply(8, 2, 8, 1'b1, 0, 1'b0);
      expect_pair("R2", 2'b10, 2'b00);
      apply(2, 8, 8, 1'b1, 5, 1'b1);
      expect_pair("R2", 2'b00, 2'b10);
   endtask

   task automatic t_r3_writeback();
      apply(11, 12, 20, 1'b1, 11, 1'b1);
      expect_pair("R3", 2'b01, 2'b00);
      apply(11, 12, 20, 1'b1, 12, 1'b1);
      expect_pair("R3", 2'b00, 2'b01);
   endtask

   task automatic t_r4_priority();
      apply(6, 6, 6, 1'b1, 6, 1'b1);
      expect_pair("R4", 2'b10, 2'b10);
      apply(31, 1, 31, 1'b1, 31, 1'b1);
      expect_pair("R4", 2'b10, 2'b00);
   endtask

   task automatic t_r5_wen_low();
      apply(6, 6, 6, 1'b0, 6, 1'b1);
      expect_pair("R5", 2'b01, 2'b01);
      apply(6, 9, 6, 1'b0, 6, 1'b0);
      expect_pair("R5", 2'b00, 2'b00);
      apply(9, 6, 9, 1'b1, 9, 1'b0);
      expect_pair("R5", 2'b10, 2'b00);
   endtask

   task automatic t_r6_zero();
      apply(0, 0, 0, 1'b1, 0, 1'b1);
      expect_pair("R6", 2'b00, 2'b00);
      apply(0, 5, 0, 1'b1, 5, 1'b1);
      expect_pair("R6", 2'b00, 2'b01);
   endtask

   task automatic t_r7_independent();
      apply(13, 14, 13, 1'b1, 14, 1'b1);
      expect_pair("R7", 2'b10, 2'b01);
      apply(14, 13, 13, 1'b1, 14, 1'b1);
      expect_pair("R7", 2'b01, 2'b10);
      apply(13, 22, 17, 1'b1, 13, 1'b1);
      expect_pair("R7", 2'b01, 2'b00);
   endtask

   task automatic t_r8_code11();
      for (int s = 0; s < 4; s++) begin
         logic [XLEN-1:0] e;
         @(negedge clk);
         m_sel = 2'(s);
         #1;
         e = (s == 2) ? 32'hBBBB_0002 : (s == 1) ? 32'hCCCC_0003 : 32'hAAAA_0001;
         chk("R8", "mux y", m_y, e);
      end
      // sweep matches: top selects must never read 11
      for (int d = 0; d < 4; d++) begin
         apply(d, 3 - d, d, 1'b1, 3 - d, 1'b1);
         chk("R8", "sel_a not 11", XLEN'(sel_a == 2'b11), '0);
         chk("R8", "sel_b not 11", XLEN'(sel_b == 2'b11), '0);
      end
   endtask

   task automatic t_r9_non_raw();
      // WAW/WAR: later stages write registers not read in execute
      apply(2, 3, 10, 1'b1, 10, 1'b1);
      expect_pair("R9", 2'b00, 2'b00);
      // RAR: both operands read the same register, no writer matches
      apply(4, 4, 15, 1'b1, 16, 1'b1);
      expect_pair("R9", 2'b00, 2'b00);
   endtask

   initial begin
      ex_rf_a = 32'h1111_AAAA;
      ex_rf_b = 32'h2222_BBBB;
      xm_alu  = 32'h3333_CCCC;
      mw_val  = 32'h4444_DDDD;
      m_sel   = 2'b00;
      ex_src_a = '0; ex_src_b = '0; xm_dst = '0; mw_dst = '0;
      xm_wen = 1'b0; mw_wen = 1'b0;
      repeat (2) @(posedge clk);
      // initial state: all-quiet inputs give register-file operands (R1)
      #1;
      expect_pair("R1", 2'b00, 2'b00);
      t_r1_idle();
      t_r2_back_to_back();
      t_r3_writeback();
      t_r4_priority();
      t_r5_wen_low();
      t_r6_zero();
      t_r7_independent();
      t_r8_code11();
      t_r9_non_raw();
      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (20000) @(posedge clk);
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule